// File: doc/BRIEF.md
# Exception-Return Status Unstacker

This block owns the 32-bit processor status word and applies the status side of a return from an exception or from a non-maskable interrupt. The status word keeps older privilege and flag contexts packed in 10-bit groups. A return discards the newest group by shifting the word right by ten places. The two most significant bits stay where they are. Then a few flags are set, depending on the old word and on the kind of return.

When the popped word shows that user mode is being re-entered, the block tells the register file to save the running stack pointer as the kernel stack pointer and to load the stack pointer from the saved user stack pointer. A return request is a one-cycle strobe. Ordinary writes to the status word always win a cycle they share with a return. A return that loses is held pending and is applied in the first cycle without such a write.

Top module: `xret_status_unstack`

## Requirements
- R1: After reset the status word is 0x00000000, and `ret_done`, `ret_pending`, `sp_ld_en` and `ksp_ld_en` are all low.
- R2: On an accepted return, new status bits [31:30] equal the old bits [31:30], bits [29:18] are zero, and bits [17:0] equal old bits [27:10], apart from the flag settings of R3 and R4.
- R3: On either kind of return, bit 7 (privilege-pending flag) of the new status is set when bit 8 (restore flag) of the old, unshifted status was clear; otherwise bit 7 keeps its shifted value (old bit 17).
- R4: A return with `ret_nmi`=1 always sets bit 9 of the new status. A return with `ret_nmi`=0 leaves bit 9 at its shifted value (old bit 19).
- R5: When bit 8 (user flag) of the shifted word is set, `ksp_ld_en` and `sp_ld_en` pulse high for one cycle, with `ksp_ld_data` equal to `sp_cur` and `sp_ld_data` equal to `usp_cur` as sampled at acceptance. When that bit is clear, neither pulses.
- R6: A return accepted at a clock edge shows its new status and `ret_done`=1 right after that edge. `ret_done` lasts exactly one cycle.
- R7: When `st_wr_en` and `ret_valid` are high in the same cycle, the write is applied, `ret_pending` goes high, and the return is applied to the written value in the first following cycle with `st_wr_en` low.
- R8: A status write with no return loads `st_wr_data` unchanged.
- R9: A return strobe that arrives while another return is pending is dropped: only one pop happens, with the kind of the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_wr_en | input | 1 | Ordinary status write strobe |
| st_wr_data | input | 32 | Value for an ordinary status write |
| ret_valid | input | 1 | Return strobe |
| ret_nmi | input | 1 | Kind of return: 1 = from NMI, 0 = from exception |
| sp_cur | input | 32 | Current stack pointer |
| usp_cur | input | 32 | Saved user stack pointer |
| status | output | 32 | Status word |
| ret_done | output | 1 | Pulses the cycle after a return is applied |
| ret_pending | output | 1 | A return is waiting for a cycle free of writes |
| sp_ld_en | output | 1 | Load the stack pointer |
| sp_ld_data | output | 32 | Value for the stack pointer |
| ksp_ld_en | output | 1 | Load the kernel stack pointer |
| ksp_ld_data | output | 32 | Value for the kernel stack pointer |

## Verification
The pop is driven with a walking one over all 32 status bits, for both kinds of return. Each bit's landing place, or its loss, is therefore seen on its own: the kept top bits, the dropped bits 29:28, the shifted-away low group, and the bits that become the user, restore and pending flags. Dense patterns such as all ones, alternating bits and user-flag-only words then show that the flag settings combine correctly with the shifted data. Write-versus-return collisions, including a second strobe during a pending return, separate a correct "write wins, then pop once with the first kind" from popping the stale value or popping twice.

// File: rtl/xret_pkg.sv
package xret_pkg;
  typedef enum logic {
    RK_EXC = 1'b0,
    RK_NMI = 1'b1
  } ret_kind_e;
endpackage

// File: rtl/xret_pop.sv
// Combinational pop of one context group plus the return-specific flags.
module xret_pop #(
  parameter int W     = 32,
  parameter int GRP   = 10,
  parameter int KEEP  = 2,
  parameter int GAP   = 2,
  parameter int U_BIT = 8,
  parameter int P_BIT = 7,
  parameter int M_BIT = 9,
  parameter int R_BIT = 8
) (
  input  logic [W-1:0]       pre,
  input  xret_pkg::ret_kind_e kind,
  output logic [W-1:0]       post,
  output logic               user
);
  localparam int LOW_W = W - KEEP;
  localparam int SRC_W = W - KEEP - GAP;

  logic [LOW_W-1:0] low_src;
  logic [LOW_W-1:0] low_sh;
  logic [W-1:0]     shifted;

  always_comb begin
    low_src = {{GAP{1'b0}}, pre[SRC_W-1:0]};
    low_sh  = low_src >> GRP;
    shifted = {pre[W-1 -: KEEP], low_sh};
    user    = shifted[U_BIT];
    post    = shifted;
    if (!pre[R_BIT]) begin
      post[P_BIT] = 1'b1;
    end
    if (kind == xret_pkg::RK_NMI) begin
      post[M_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/xret_arb.sv
// Holds a return request that collides with a status write.
module xret_arb (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_nmi,
  input  logic                wr_busy,
  output logic                acc,
  output xret_pkg::ret_kind_e acc_kind,
  output logic                pending
);
  logic pend_q, pend_d;
  logic pnmi_q, pnmi_d;

  always_comb begin
    acc      = (pend_q | req_valid) & ~wr_busy;
    acc_kind = xret_pkg::ret_kind_e'(pend_q ? pnmi_q : req_nmi);
    pend_d   = pend_q;
    pnmi_d   = pnmi_q;
    if (acc) begin
      pend_d = 1'b0;
    end else if (req_valid && !pend_q) begin
      pend_d = 1'b1;
      pnmi_d = req_nmi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pnmi_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pnmi_q <= pnmi_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/xret_status_unstack.sv
module xret_status_unstack #(
  parameter int W     = 32,
  parameter int GRP   = 10,
  parameter int KEEP  = 2,
  parameter int GAP   = 2,
  parameter int U_BIT = 8,
  parameter int P_BIT = 7,
  parameter int M_BIT = 9,
  parameter int R_BIT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         st_wr_en,
  input  logic [31:0]  st_wr_data,
  input  logic         ret_valid,
  input  logic         ret_nmi,
  input  logic [31:0]  sp_cur,
  input  logic [31:0]  usp_cur,
  output logic [31:0]  status,
  output logic         ret_done,
  output logic         ret_pending,
  output logic         sp_ld_en,
  output logic [31:0]  sp_ld_data,
  output logic         ksp_ld_en,
  output logic [31:0]  ksp_ld_data
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                acc;
  xret_pkg::ret_kind_e acc_kind;
  logic                acc_nmi;
  logic [W-1:0]        popped;
  logic                pop_user;

  xret_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_valid(ret_valid),
    .req_nmi  (ret_nmi),
    .wr_busy  (st_wr_en),
    .acc      (acc),
    .acc_kind (acc_kind),
    .pending  (ret_pending)
  );
  assign acc_nmi = (acc_kind == xret_pkg::RK_NMI);

  logic [W-1:0] st_q, st_d;
  logic         done_q, done_d;
  logic         ld_q, ld_d;
  logic [W-1:0] spd_q, spd_d;
  logic [W-1:0] kspd_q, kspd_d;

  xret_pop #(
    .W(W), .GRP(GRP), .KEEP(KEEP), .GAP(GAP),
    .U_BIT(U_BIT), .P_BIT(P_BIT), .M_BIT(M_BIT), .R_BIT(R_BIT)
  ) u_pop (
    .pre (st_q),
    .kind(acc_kind),
    .post(popped),
    .user(pop_user)
  );

  always_comb begin
    st_d   = st_q;
    done_d = acc;
    ld_d   = acc & pop_user;
    spd_d  = spd_q;
    kspd_d = kspd_q;
    if (st_wr_en) begin
      st_d = st_wr_data;
    end else if (acc) begin
      st_d = popped;
    end
    if (acc && pop_user) begin
      spd_d  = usp_cur;
      kspd_d = sp_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= '0;
      done_q <= 1'b0;
      ld_q   <= 1'b0;
      spd_q  <= '0;
      kspd_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      ld_q   <= ld_d;
      spd_q  <= spd_d;
      kspd_q <= kspd_d;
    end
  end

  assign status      = st_q;
  assign ret_done    = done_q;
  assign sp_ld_en    = ld_q;
  assign ksp_ld_en   = ld_q;
  assign sp_ld_data  = spd_q;
  assign ksp_ld_data = kspd_q;
endmodule

// File: rtl/xret_chk.sv
module xret_chk #(
  parameter int W     = 32,
  parameter int KEEP  = 2,
  parameter int GAP   = 2,
  parameter int U_BIT = 8,
  parameter int P_BIT = 7,
  parameter int M_BIT = 9,
  parameter int R_BIT = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         st_wr_en,
  input logic [W-1:0] st_wr_data,
  input logic [W-1:0] status,
  input logic         ret_done,
  input logic         sp_ld_en,
  input logic         ksp_ld_en,
  input logic         acc,
  input logic         acc_nmi
);
  // R1
  idle_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_done |-> !sp_ld_en);
  // R2
  top_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |-> (status[W-1 -: KEEP] == $past(status[W-1 -: KEEP])) &&
                 (status[W-KEEP-1 -: GAP] == '0));
  // R3
  pflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_done && !$past(status[R_BIT])) |-> status[P_BIT]);
  // R4
  mflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_done && $past(acc_nmi)) |-> status[M_BIT]);
  // R5
  user_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |-> (sp_ld_en == status[U_BIT]) && (ksp_ld_en == sp_ld_en));
  // R6
  no_write_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_done |-> $past(!st_wr_en));
  // R6
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ret_done);
  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |=> (status == $past(st_wr_data)));
endmodule

bind xret_status_unstack xret_chk #(
  .W(W), .KEEP(KEEP), .GAP(GAP),
  .U_BIT(U_BIT), .P_BIT(P_BIT), .M_BIT(M_BIT), .R_BIT(R_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .st_wr_en  (st_wr_en),
  .st_wr_data(st_wr_data),
  .status    (status),
  .ret_done  (ret_done),
  .sp_ld_en  (sp_ld_en),
  .ksp_ld_en (ksp_ld_en),
  .acc       (acc),
  .acc_nmi   (acc_nmi)
);

// File: tb/xret_status_unstack_tb.sv
module xret_status_unstack_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        st_wr_en;
  logic [31:0] st_wr_data;
  logic        ret_valid;
  logic        ret_nmi;
  logic [31:0] sp_cur;
  logic [31:0] usp_cur;
  logic [31:0] status;
  logic        ret_done;
  logic        ret_pending;
  logic        sp_ld_en;
  logic [31:0] sp_ld_data;
  logic        ksp_ld_en;
  logic [31:0] ksp_ld_data;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  xret_status_unstack u_dut (
    .clk(clk), .rst_n(rst_n), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .ret_valid(ret_valid), .ret_nmi(ret_nmi), .sp_cur(sp_cur), .usp_cur(usp_cur),
    .status(status), .ret_done(ret_done), .ret_pending(ret_pending),
    .sp_ld_en(sp_ld_en), .sp_ld_data(sp_ld_data),
    .ksp_ld_en(ksp_ld_en), .ksp_ld_data(ksp_ld_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      finish_run();
    end
  end

  function automatic logic [31:0] model_pop(input logic [31:0] s, input bit nmi);
    logic [31:0] r;
    r = (s & 32'hC000_0000) | ((s & 32'h0FFF_FFFF) >> 10);
    if (!s[8]) r[7] = 1'b1;
    if (nmi)   r[9] = 1'b1;
    return r;
  endfunction

  function automatic bit model_user(input logic [31:0] s);
    logic [31:0] r;
    r = (s & 32'h0FFF_FFFF) >> 10;
    return r[8];
  endfunction

  // write s, return with kind nmi, check everything
  task automatic run_pop(input logic [31:0] s, input bit nmi);
    logic [31:0] e;
    logic [31:0] ksp_v;
    logic [31:0] usp_v;
    bit          u;
    e     = model_pop(s, nmi);
    u     = model_user(s);
    ksp_v = s ^ 32'h1357_9BDF;
    usp_v = ~s;
    @(negedge clk);
    st_wr_en = 1'b1; st_wr_data = s; ret_valid = 1'b0;
    @(negedge clk);
    // R8
    check(status == s, "R8 write", status, s);
    st_wr_en = 1'b0; ret_valid = 1'b1; ret_nmi = nmi;
    sp_cur = ksp_v; usp_cur = usp_v;
    @(negedge clk);
    ret_valid = 1'b0; sp_cur = 32'h0; usp_cur = 32'h0;
    // R2: data bits other than the flag positions 7 and 9
    check((status & ~32'h0000_0280) == (e & ~32'h0000_0280), "R2 pop", status, e);
    // R3
    check(status[7] == e[7], "R3 pflag", {31'b0, status[7]}, {31'b0, e[7]});
    // R4
    check(status[9] == e[9], "R4 mflag", {31'b0, status[9]}, {31'b0, e[9]});
    // R6
    check(ret_done == 1'b1, "R6 done", {31'b0, ret_done}, 32'd1);
    // R5
    check(sp_ld_en == u && ksp_ld_en == u, "R5 load enables",
          {30'b0, sp_ld_en, ksp_ld_en}, {30'b0, u, u});
    if (u) begin
      check(sp_ld_data == usp_v, "R5 sp value", sp_ld_data, usp_v);
      check(ksp_ld_data == ksp_v, "R5 ksp value", ksp_ld_data, ksp_v);
    end
    @(negedge clk);
    // R6: single pulse, no second pop
    check(ret_done == 1'b0 && sp_ld_en == 1'b0, "R6 pulse",
          {30'b0, ret_done, sp_ld_en}, 32'd0);
    check(status == e, "R6 hold", status, e);
  endtask

  logic [31:0] pats [8];

  initial begin
    rst_n = 1'b0; st_wr_en = 1'b0; st_wr_data = '0; ret_valid = 1'b0;
    ret_nmi = 1'b0; sp_cur = '0; usp_cur = '0;
    repeat (3) @(negedge clk);
    // R1
    check(status == 32'h0, "R1 status", status, 32'h0);
    check({ret_done, ret_pending, sp_ld_en, ksp_ld_en} == 4'b0, "R1 flags",
          {28'b0, ret_done, ret_pending, sp_ld_en, ksp_ld_en}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(status == 32'h0 && !ret_done, "R1 after release", status, 32'h0);

    for (int k = 0; k < 2; k++) begin
      for (int b = 0; b < 32; b++) begin
        run_pop(32'h1 << b, k[0]);
      end
    end
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h0004_0000; pats[3] = 32'h0004_0100;
    pats[4] = 32'hA5A5_A5A5; pats[5] = 32'h5A5A_5A5A;
    pats[6] = 32'hF000_0000; pats[7] = 32'h000E_0100;
    for (int k = 0; k < 2; k++) begin
      for (int p = 0; p < 8; p++) begin
        run_pop(pats[p], k[0]);
      end
    end

    // R7: write and return in the same cycle
    @(negedge clk);
    st_wr_en = 1'b1; st_wr_data = 32'hC004_0000; ret_valid = 1'b1; ret_nmi = 1'b1;
    @(negedge clk);
    st_wr_en = 1'b0; ret_valid = 1'b0;
    check(status == 32'hC004_0000, "R7 write wins", status, 32'hC004_0000);
    check(ret_pending == 1'b1 && ret_done == 1'b0, "R7 pending",
          {30'b0, ret_pending, ret_done}, 32'd2);
    @(negedge clk);
    check(status == model_pop(32'hC004_0000, 1'b1), "R7 delayed pop", status,
          model_pop(32'hC004_0000, 1'b1));
    check(ret_done == 1'b1 && ret_pending == 1'b0, "R7 done",
          {30'b0, ret_done, ret_pending}, 32'd2);

    // R9: second strobe while pending is dropped, first kind kept
    @(negedge clk);
    st_wr_en = 1'b1; st_wr_data = 32'h1111_1111; ret_valid = 1'b1; ret_nmi = 1'b0;
    @(negedge clk);
    st_wr_data = 32'h0000_0000; ret_valid = 1'b1; ret_nmi = 1'b1;
    @(negedge clk);
    st_wr_en = 1'b0; ret_valid = 1'b0;
    check(status == 32'h0 && ret_pending, "R9 second write", status, 32'h0);
    @(negedge clk);
    check(status == 32'h0000_0080, "R9 kind of first", status, 32'h0000_0080);
    @(negedge clk);
    check(status == 32'h0000_0080 && !ret_done && !ret_pending, "R9 single pop",
          status, 32'h0000_0080);
    finish_run();
  end
endmodule